// File: doc/BRIEF.md
# Burst Subframe Chirp Sequencer

This block walks the nested structure of an advanced radar frame and emits one chirp-start strobe per clock while a burst is playing, together with the 9-bit chirp index and the number of the subframe that the chirp belongs to. A burst plays a run of consecutive unique chirps and repeats that run a set number of times with no gap. A subframe is a set of bursts, and that set is itself repeated. A frame is one to four subframes, and frames repeat a programmed number of times or without end. The waveform timing inside a chirp is handled downstream. This block only decides which chirp starts and when.

Each subframe has its own configuration: start index, chirps per burst, loops per burst, bursts per set, set repeats, index step, burst period and subframe period. Periods are counted in clock ticks, one tick per 5 ns unit. A new burst starts only when its period has elapsed since the previous burst started. The first burst of a new subframe also waits for the subframe period. Before each frame, and optionally before each subframe or each burst, the sequencer waits for a trigger-accepted strobe. A stop request lets the current burst finish and then returns the block to idle.

Top module: `cseq_top`

## Requirements
- R1: Under reset, and after it, the block is idle: `busy`, `chirp_stb` and `done` are all low.
- R2: A `start` pulse seen while idle raises `busy` at the next edge. No chirp is strobed until `trig_acc` is sampled high. The first strobe appears in the cycle after the edge that sampled `trig_acc`.
- R3: Inside a burst, one strobe is issued per clock with no gap. The index is `(burst_base + k) mod 512` for k = 0 to chirps-1, and this run is repeated `sf_loops` times back to back.
- R4: The base of the next burst inside a burst set is computed mod 512. With a step of 0 the base is unchanged. With a non-zero step it is `(previous base + chirps - 1 + step) mod 512`.
- R5: A subframe plays `sf_bursts` bursts, then restarts at its own `sf_start_idx` and plays the set `sf_burst_loops` times. It therefore emits chirps × loops × bursts × burst_loops strobes.
- R6: Inside a subframe, when no trigger is needed, the first strobe of the next burst comes max(N+1, P) cycles after the first strobe of the previous burst. N is chirps × loops and P is `sf_burst_per`.
- R7: Subframes are played in order 0 to `num_sf`-1, and `chirp_sf` carries the current one. When no trigger is needed, the last burst of a subframe is followed by the next subframe no earlier than S + `sf_sub_per`, where S is the cycle of the subframe's first strobe. The burst-level rule of R6 also still applies.
- R8: Trigger granularity `trig_gran` is coded as 0 = frame, 1 = subframe, 2 or 3 = burst. A wait for `trig_acc` is inserted before every frame, and also before every subframe (code 1 or above) or before every burst (code 2 or 3). Each wait costs at least one cycle. `trig_acc` has no effect outside a wait.
- R9: After `num_frames` frames the block returns to idle and pulses `done` high for exactly one cycle, in the first idle cycle. A `num_frames` of 0 repeats frames until a stop request.
- R10: A `stop` request during a burst lets that burst's remaining strobes complete. `busy` then drops in the cycle after the last chirp, and no `done` is given. A stop request while waiting for a trigger drops `busy` at the next edge.
- R11: A `start` pulse while busy is ignored and does not disturb the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per period unit |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run of frames (idle only) |
| stop | input | 1 | Stop request; current burst completes |
| trig_acc | input | 1 | Trigger-accepted strobe |
| trig_gran | input | 2 | Trigger granularity: 0 frame, 1 subframe, 2/3 burst |
| num_sf | input | 3 | Subframes per frame, 1 to 4 |
| num_frames | input | 16 | Frames to play, 0 = until stop |
| sf_start_idx | input | 4×9 | Start chirp index per subframe |
| sf_chirps | input | 4×10 | Unique chirps per burst, 1 to 512 |
| sf_loops | input | 4×8 | Loops of the chirp run per burst, 1 to 255 |
| sf_bursts | input | 4×10 | Bursts per burst set, 1 to 512 |
| sf_burst_loops | input | 4×7 | Repeats of the burst set, 1 to 64 |
| sf_idx_step | input | 4×9 | Base step between bursts |
| sf_burst_per | input | 4×28 | Burst period in ticks |
| sf_sub_per | input | 4×28 | Subframe period in ticks |
| chirp_stb | output | 1 | Chirp start strobe |
| chirp_idx | output | 9 | Index of the chirp being started |
| chirp_sf | output | 2 | Subframe of the chirp being started |
| busy | output | 1 | High from start until return to idle |
| done | output | 1 | One-cycle pulse after the final frame |

## Verification
The bench aims at index arithmetic that crosses 511. A design that wraps in the wrong place, or adds the step to the start of the burst instead of its last chirp, shows a wrong index on the first chirp of a later burst. A step of 0 is played against a non-zero step in another subframe, because a design that treats 0 as an ordinary step drifts by chirps-1 per burst. Long burst and subframe periods next to short ones expose a timer compared against the wrong limit, or restarted at the wrong unit, as a strobe one or more cycles early or late. Stops placed mid-burst and during a trigger wait, a start pulse during a run, and an endless frame count catch a design that cuts a burst short, never stops, restarts, or pulses `done` when it should not.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    // Chirp index space: 512 slots, arithmetic wraps naturally in 9 bits.
    localparam int IDX_W = 9;

    // Trigger granularity codes (bit 1 set means every burst).
    localparam logic [1:0] GRAN_FRAME    = 2'd0;
    localparam logic [1:0] GRAN_SUBFRAME = 2'd1;

    typedef enum logic [1:0] {
        S_IDLE,   // nothing scheduled
        S_WAIT,   // holding for a trigger-accepted strobe
        S_RUN,    // one chirp strobe per cycle
        S_GAP     // burst played, waiting for its periods to elapse
    } seq_state_t;

    // Base index of the following burst inside a burst set.
    function automatic logic [IDX_W-1:0] next_base(
        input logic [IDX_W-1:0] base,
        input logic [IDX_W-1:0] last_off,
        input logic [IDX_W-1:0] step
    );
        if (step == '0) return base;
        return base + last_off + step;
    endfunction

    // Whether the next unit must wait for a trigger.
    function automatic logic trig_needed(
        input logic [1:0] gran,
        input logic       sf_end,
        input logic       fr_end
    );
        if (fr_end) return 1'b1;
        if (sf_end) return gran != GRAN_FRAME;
        return gran[1];
    endfunction

endpackage

// File: rtl/cseq_timer.sv
// Elapsed-tick counter, restarted at the launch of a unit, saturating.
module cseq_timer #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         reached
);
    logic [W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            elapsed <= '0;
        end else if (elapsed != '1) begin
            elapsed <= elapsed + W'(1);
        end
    end

    // Reached when the cycle after this one is at least `limit` ticks in.
    assign reached = ({1'b0, elapsed} + (W+1)'(1)) >= {1'b0, limit};
endmodule

// File: rtl/cseq_idx_walker.sv
// Holds the current burst base and forms the chirp index from it.
module cseq_idx_walker
    import cseq_pkg::*;
#(
    parameter int CH_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             advance,
    input  logic [CH_W-1:0]  n_chirps,
    input  logic [IDX_W-1:0] step,
    input  logic [CH_W-1:0]  ck,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] last_off;

    assign last_off = IDX_W'(n_chirps - CH_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
        end else if (load) begin
            base <= load_val;
        end else if (advance) begin
            base <= next_base(base, last_off, step);
        end
    end

    assign idx = base + IDX_W'(ck);
endmodule

// File: rtl/cseq_top.sv
module cseq_top
    import cseq_pkg::*;
#(
    parameter int NSF   = 4,
    parameter int PER_W = 28,
    parameter int FR_W  = 16,
    parameter int CH_W  = 10,
    parameter int LP_W  = 8,
    parameter int BU_W  = 10,
    parameter int BL_W  = 7,
    localparam int SF_W  = $clog2(NSF),
    localparam int NSF_W = $clog2(NSF + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          stop,
    input  logic                          trig_acc,
    input  logic [1:0]                    trig_gran,
    input  logic [NSF_W-1:0]              num_sf,
    input  logic [FR_W-1:0]               num_frames,
    input  logic [NSF-1:0][IDX_W-1:0]     sf_start_idx,
    input  logic [NSF-1:0][CH_W-1:0]      sf_chirps,
    input  logic [NSF-1:0][LP_W-1:0]      sf_loops,
    input  logic [NSF-1:0][BU_W-1:0]      sf_bursts,
    input  logic [NSF-1:0][BL_W-1:0]      sf_burst_loops,
    input  logic [NSF-1:0][IDX_W-1:0]     sf_idx_step,
    input  logic [NSF-1:0][PER_W-1:0]     sf_burst_per,
    input  logic [NSF-1:0][PER_W-1:0]     sf_sub_per,
    output logic                          chirp_stb,
    output logic [IDX_W-1:0]              chirp_idx,
    output logic [SF_W-1:0]               chirp_sf,
    output logic                          busy,
    output logic                          done
);
    seq_state_t state, nxt;

    // Position inside the nest, innermost first.
    logic [CH_W-1:0] ck;
    logic [LP_W-1:0] lp;
    logic [BU_W-1:0] bu;
    logic [BL_W-1:0] bl;
    logic [SF_W-1:0] sf;
    logic [FR_W-1:0] fr;
    logic            stop_pend;
    logic            done_q;

    logic last_ck, last_lp, bu_last, bl_last, sf_last, fr_last;
    logic burst_done, sf_end, fr_end, stop_now, gap_ready;
    logic b_reached, s_reached, launch, s_first;
    logic pos_reset, pos_adv, ld, adv, fin;
    logic [IDX_W-1:0] ld_val;
    logic [SF_W-1:0]  sf_nx;

    assign last_ck    = ck == sf_chirps[sf] - CH_W'(1);
    assign last_lp    = lp == sf_loops[sf] - LP_W'(1);
    assign bu_last    = bu == sf_bursts[sf] - BU_W'(1);
    assign bl_last    = bl == sf_burst_loops[sf] - BL_W'(1);
    assign sf_last    = NSF_W'(sf) == num_sf - NSF_W'(1);
    assign fr_last    = (num_frames != '0) && (FR_W'(fr + FR_W'(1)) == num_frames);
    assign burst_done = last_ck && last_lp;
    assign sf_end     = bu_last && bl_last;
    assign fr_end     = sf_end && sf_last;
    assign stop_now   = stop || stop_pend;
    assign gap_ready  = b_reached && (!sf_end || s_reached);
    assign sf_nx      = sf + SF_W'(1);

    always_comb begin
        nxt       = state;
        pos_reset = 1'b0;
        pos_adv   = 1'b0;
        ld        = 1'b0;
        ld_val    = sf_start_idx[0];
        adv       = 1'b0;
        fin       = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    nxt       = S_WAIT;
                    pos_reset = 1'b1;
                    ld        = 1'b1;
                end
            end
            S_WAIT: begin
                if (stop_now)      nxt = S_IDLE;
                else if (trig_acc) nxt = S_RUN;
            end
            S_RUN: begin
                if (burst_done) nxt = stop_now ? S_IDLE : S_GAP;
            end
            S_GAP: begin
                if (stop_now) begin
                    nxt = S_IDLE;
                end else if (gap_ready) begin
                    if (fr_end && fr_last) begin
                        nxt = S_IDLE;
                        fin = 1'b1;
                    end else begin
                        pos_adv = 1'b1;
                        nxt = trig_needed(trig_gran, sf_end, fr_end) ? S_WAIT : S_RUN;
                        if (fr_end) begin
                            ld = 1'b1;
                        end else if (sf_end) begin
                            ld     = 1'b1;
                            ld_val = sf_start_idx[sf_nx];
                        end else if (bu_last) begin
                            ld     = 1'b1;
                            ld_val = sf_start_idx[sf];
                        end else begin
                            adv = 1'b1;
                        end
                    end
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // Timers restart the cycle before a unit's first strobe.
    assign launch  = (nxt == S_RUN) && (state != S_RUN);
    assign s_first = (state == S_GAP) ? sf_end : ((bu == '0) && (bl == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            ck        <= '0;
            lp        <= '0;
            bu        <= '0;
            bl        <= '0;
            sf        <= '0;
            fr        <= '0;
            stop_pend <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state     <= nxt;
            done_q    <= fin;
            stop_pend <= (state != S_IDLE) && (nxt != S_IDLE) && stop_now;
            if (pos_reset) begin
                ck <= '0;
                lp <= '0;
                bu <= '0;
                bl <= '0;
                sf <= '0;
                fr <= '0;
            end else begin
                if (state == S_RUN) begin
                    if (last_ck) begin
                        ck <= '0;
                        lp <= last_lp ? '0 : lp + LP_W'(1);
                    end else begin
                        ck <= ck + CH_W'(1);
                    end
                end
                if (pos_adv) begin
                    if (!bu_last) begin
                        bu <= bu + BU_W'(1);
                    end else begin
                        bu <= '0;
                        if (!bl_last) begin
                            bl <= bl + BL_W'(1);
                        end else begin
                            bl <= '0;
                            if (!sf_last) begin
                                sf <= sf_nx;
                            end else begin
                                sf <= '0;
                                fr <= fr + FR_W'(1);
                            end
                        end
                    end
                end
            end
        end
    end

    cseq_timer #(.W(PER_W)) u_burst_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (launch),
        .limit   (sf_burst_per[sf]),
        .reached (b_reached)
    );

    cseq_timer #(.W(PER_W)) u_sub_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (launch && s_first),
        .limit   (sf_sub_per[sf]),
        .reached (s_reached)
    );

    cseq_idx_walker #(.CH_W(CH_W)) u_walker (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .advance  (adv),
        .n_chirps (sf_chirps[sf]),
        .step     (sf_idx_step[sf]),
        .ck       (ck),
        .idx      (chirp_idx)
    );

    assign chirp_stb = state == S_RUN;
    assign chirp_sf  = sf;
    assign busy      = state != S_IDLE;
    assign done      = done_q;
endmodule

// File: rtl/cseq_checks.sv
module cseq_checks #(
    parameter int NSF   = 4,
    localparam int SF_W  = $clog2(NSF),
    localparam int NSF_W = $clog2(NSF + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             chirp_stb,
    input logic [SF_W-1:0]  chirp_sf,
    input logic [NSF_W-1:0] num_sf,
    input logic             busy,
    input logic             done
);
    // R1, R10: no strobe ever leaves an idle sequencer
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !chirp_stb);

    // R2: a start from idle raises busy but waits for a trigger
    a_r2_start_waits: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !chirp_stb));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: done only appears once the block is idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: strobed subframe number stays below the programmed count
    a_r7_sf_range: assert property (@(posedge clk) disable iff (rst)
        chirp_stb |-> (NSF_W'(chirp_sf) < num_sf));
endmodule

bind cseq_top cseq_checks #(.NSF(NSF)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .chirp_stb (chirp_stb),
    .chirp_sf  (chirp_sf),
    .num_sf    (num_sf),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_cseq_top.sv
module test_cseq_top;
    localparam int NSF = 4, PER_W = 28, FR_W = 16, CH_W = 10;
    localparam int LP_W = 8, BU_W = 10, BL_W = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, stop = 1'b0, trig_acc = 1'b0;
    logic [1:0] trig_gran = '0;
    logic [2:0] num_sf = 3'd1;
    logic [FR_W-1:0] num_frames = '0;
    logic [NSF-1:0][8:0]       sf_start_idx = '0;
    logic [NSF-1:0][CH_W-1:0]  sf_chirps = '0;
    logic [NSF-1:0][LP_W-1:0]  sf_loops = '0;
    logic [NSF-1:0][BU_W-1:0]  sf_bursts = '0;
    logic [NSF-1:0][BL_W-1:0]  sf_burst_loops = '0;
    logic [NSF-1:0][8:0]       sf_idx_step = '0;
    logic [NSF-1:0][PER_W-1:0] sf_burst_per = '0;
    logic [NSF-1:0][PER_W-1:0] sf_sub_per = '0;
    logic       chirp_stb, busy, done;
    logic [8:0] chirp_idx;
    logic [1:0] chirp_sf;

    always #4 clk = ~clk;

    cseq_top i_cseq_top (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .trig_acc(trig_acc),
        .trig_gran(trig_gran), .num_sf(num_sf), .num_frames(num_frames),
        .sf_start_idx(sf_start_idx), .sf_chirps(sf_chirps), .sf_loops(sf_loops),
        .sf_bursts(sf_bursts), .sf_burst_loops(sf_burst_loops),
        .sf_idx_step(sf_idx_step), .sf_burst_per(sf_burst_per),
        .sf_sub_per(sf_sub_per), .chirp_stb(chirp_stb), .chirp_idx(chirp_idx),
        .chirp_sf(chirp_sf), .busy(busy), .done(done)
    );

    int cyc = 0, n_chk = 0, n_err = 0;
    int exp_idx[int];
    int exp_sf[int];
    int exp_bend[int];
    int busy_from = 1000000000, busy_to = 0, done_t = -1;
    string tag = "R1";

    task automatic chk_cycle();
        bit e_stb, e_busy, e_done;
        int e_i, e_s;
        e_stb  = exp_idx.exists(cyc);
        e_busy = (cyc >= busy_from) && (cyc < busy_to);
        e_done = (cyc == done_t);
        e_i = e_stb ? exp_idx[cyc] : 0;
        e_s = e_stb ? exp_sf[cyc] : 0;
        n_chk++;
        if (chirp_stb !== e_stb || busy !== e_busy || done !== e_done ||
            (e_stb && (int'(chirp_idx) != e_i || int'(chirp_sf) != e_s))) begin
            n_err++;
            $display("FAIL %s cyc %0d stb/idx/sf/busy/done actual %0b/%0d/%0d/%0b/%0b expected %0b/%0d/%0d/%0b/%0b",
                     tag, cyc, chirp_stb, chirp_idx, chirp_sf, busy, done,
                     e_stb, e_i, e_s, e_busy, e_done);
        end
    endtask

    task automatic step();
        @(posedge clk);
        cyc++;
        @(negedge clk);
        chk_cycle();
    endtask

    task automatic set_sf(input int s, input int st, input int nc, input int nl,
                          input int nb, input int nbl, input int stp,
                          input int bp, input int sp);
        sf_start_idx[s]   = 9'(st);
        sf_chirps[s]      = CH_W'(nc);
        sf_loops[s]       = LP_W'(nl);
        sf_bursts[s]      = BU_W'(nb);
        sf_burst_loops[s] = BL_W'(nbl);
        sf_idx_step[s]    = 9'(stp);
        sf_burst_per[s]   = PER_W'(bp);
        sf_sub_per[s]     = PER_W'(sp);
    endtask

    // Expected schedule from the requirements; trig_acc held high after t0.
    task automatic build(input int t0, input int nfg, output int tend, output int lastfs);
        int t, base, r, n, lb, s0, need, nc, nl, nb, nbl, stp, bp, sp, g, ns;
        bit sfe, fre;
        t = t0; g = int'(trig_gran); ns = int'(num_sf);
        tend = t0; lastfs = t0;
        for (int f = 0; f < nfg; f++) begin
            for (int s = 0; s < ns; s++) begin
                s0 = t;
                if (f == nfg - 1 && s == 0) lastfs = t;
                nc = int'(sf_chirps[s]); nl = int'(sf_loops[s]);
                nb = int'(sf_bursts[s]); nbl = int'(sf_burst_loops[s]);
                stp = int'(sf_idx_step[s]);
                bp = int'(sf_burst_per[s]); sp = int'(sf_sub_per[s]);
                for (int bl = 0; bl < nbl; bl++) begin
                    base = int'(sf_start_idx[s]);            // R5 restart per set
                    for (int b = 0; b < nb; b++) begin
                        lb = t; n = nc * nl;
                        for (int l = 0; l < nl; l++)
                            for (int c = 0; c < nc; c++) begin
                                exp_idx[lb + l*nc + c]  = (base + c) % 512;   // R3
                                exp_sf[lb + l*nc + c]   = s;
                                exp_bend[lb + l*nc + c] = lb + n;
                            end
                        sfe = (b == nb - 1) && (bl == nbl - 1);
                        fre = sfe && (s == ns - 1);
                        r = lb + n;                                   // R6
                        if (lb + bp - 1 > r) r = lb + bp - 1;
                        if (sfe && s0 + sp - 1 > r) r = s0 + sp - 1;  // R7
                        if (fre && f == nfg - 1) tend = r + 1;
                        need = fre ? 1 : (sfe ? int'(g >= 1) : int'(g >= 2));  // R8
                        t = r + 1 + need;
                        if (stp != 0) base = (base + nc - 1 + stp) % 512;    // R4
                    end
                end
            end
        end
    endtask

    task automatic run_test(input string t, input int w, input int nfg,
                            input bit do_stop, input int extra_start);
        int t0, tend, lastfs, stop_x, e;
        int keys[$];
        tag = t;
        trig_acc = (w == 0);
        start = 1'b1;
        busy_from = cyc + 1; busy_to = 1000000000; done_t = -1;
        step();
        start = 1'b0;
        repeat (w) step();                     // R2: no strobe while waiting
        trig_acc = 1'b1;
        t0 = cyc + 1;
        build(t0, nfg, tend, lastfs);
        busy_to = tend;
        done_t  = (num_frames != 0) ? tend : -1;
        stop_x  = do_stop ? lastfs + 1 : -1;
        while (cyc < busy_to + 3) begin
            if (cyc == stop_x) begin           // R10: finish current burst
                e = exp_bend[cyc];
                keys.delete();
                foreach (exp_idx[k]) if (k >= e) keys.push_back(k);
                foreach (keys[i]) exp_idx.delete(keys[i]);
                busy_to = e; done_t = -1;
                stop = 1'b1;
            end
            if (extra_start >= 0 && cyc == t0 + extra_start) start = 1'b1;  // R11
            step();
            stop = 1'b0;
            start = 1'b0;
        end
        exp_idx.delete(); exp_sf.delete(); exp_bend.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired at cyc %0d expected completion", cyc);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) step();
        rst = 1'b0;
        repeat (3) step();

        // R3 R4 R6: one subframe, bursts paced by a long burst period
        num_sf = 3'd1; num_frames = 16'd1; trig_gran = 2'd0;
        set_sf(0, 10, 3, 2, 3, 1, 2, 12, 0);
        run_test("R3 R4 R6", 0, 1, 1'b0, -1);

        // R2: trigger held low for several cycles after start
        run_test("R2", 4, 1, 1'b0, -1);

        // R4: wrap past 511 with a step, and step 0 in the second subframe
        num_sf = 3'd2;
        set_sf(0, 508, 4, 1, 3, 1, 5, 0, 0);
        set_sf(1, 100, 2, 3, 2, 1, 0, 0, 0);
        run_test("R4", 0, 1, 1'b0, -1);

        // R5 R7: repeated burst sets, long subframe period, subframe triggers
        trig_gran = 2'd1;
        set_sf(0, 0, 2, 1, 2, 3, 3, 5, 60);
        set_sf(1, 300, 1, 4, 1, 2, 0, 0, 0);
        run_test("R5 R7", 0, 1, 1'b0, -1);

        // R8: burst-level triggers across three subframes, one wrapping
        num_sf = 3'd3; trig_gran = 2'd2;
        set_sf(0, 20, 2, 1, 2, 1, 1, 0, 0);
        set_sf(1, 40, 1, 2, 2, 1, 0, 0, 0);
        set_sf(2, 511, 3, 1, 2, 1, 1, 0, 0);
        run_test("R8", 2, 1, 1'b0, -1);

        // R9 R11: two frames with done, stray start during the run
        num_sf = 3'd2; num_frames = 16'd2; trig_gran = 2'd1;
        run_test("R9 R11", 0, 2, 1'b0, 5);

        // R9 R10: endless frames stopped mid-burst in the third frame
        num_sf = 3'd1; num_frames = 16'd0; trig_gran = 2'd3;
        set_sf(0, 5, 2, 2, 2, 1, 4, 6, 20);
        run_test("R9 R10", 0, 3, 1'b1, -1);

        // R10: stop while waiting for a trigger
        tag = "R10";
        trig_acc = 1'b0;
        start = 1'b1;
        busy_from = cyc + 1; busy_to = 1000000000; done_t = -1;
        step();
        start = 1'b0;
        step();
        stop = 1'b1;
        busy_to = cyc + 1;
        step();
        stop = 1'b0;
        repeat (4) step();

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule